// File: doc/BRIEF.md
# Text Terminal Character Engine

This block sits between a byte stream (a serial console, a debug monitor) and a character-cell text buffer. Each byte is taken when `in_valid` is high and `busy` is low. The block keeps the cursor column and row, the current colour attribute, a cursor-visible flag and the state of a small escape-sequence parser. It writes 16-bit cells into an external text buffer. Each cell holds the attribute in bits 15:8 and the character code in bits 7:0. The buffer is addressed linearly as row*COLS + column. Reads from it return data one cycle after `buf_re`.

Single-byte cursor codes move the cursor inside a 56 x 31 grid. Bytes that are neither control codes nor part of an escape sequence are written as attributed characters. Line editing (delete, backspace, clear to end of line) runs as a multi-cycle sweep along the current row. During a sweep `busy` is high, one buffer access is made per cycle and input bytes are dropped. Scrolling itself is not done here: the block pulses `scroll_up` for one cycle and leaves the cursor on the bottom row.

States: ST_IDLE takes a byte and dispatches it. ST_ESC is entered on ESC. From ST_ESC, "`" goes to ST_CURSW and "(" goes to ST_ATT_OPEN; "T" starts ST_CLEAR; "W" starts ST_FETCH, or ST_BLANK when the cursor is at the last column; any other byte returns to ST_IDLE. ST_CURSW returns to ST_IDLE on any byte. ST_ATT_OPEN goes to ST_ATT_ESC on ESC and otherwise to ST_IDLE. ST_ATT_ESC goes to ST_ATT_SEL on "G" and otherwise to ST_IDLE. ST_ATT_SEL returns to ST_IDLE on any byte. The edit sweep runs ST_FETCH to ST_STORE, then repeats ST_FETCH or goes to ST_BLANK after the store that targets column 54. ST_CLEAR loops until it has written column 55. ST_BLANK returns to ST_IDLE.

Top module: `term_char_engine`

## Requirements
- R1: After reset the cursor is at column 0, row 0, `cursor_pos` is 0, the attribute is 0xBF, the cursor is visible, `busy` is low and the parser is idle.
- R2: A byte other than 0x08, 0x0A, 0x0D, 0x1B, 0x90–0x94 or 0x99, received while idle, is written to the cell at the cursor as {attribute, byte}. The cursor then advances one column, or goes to column 0 of the next row when it was at column 55.
- R3: A line feed (0x0A) on row 30, or a character printed at column 55 of row 30, pulses `scroll_up` for one cycle and leaves the cursor on row 30. A character printed there also moves the cursor to column 0.
- R4: 0x91 moves the cursor right and 0x93 moves it left; neither has any effect at column 55 or column 0 respectively. The column always stays within 0–55.
- R5: 0x92 moves the cursor down and 0x90 moves it up; neither has any effect at row 30 or row 0 respectively.
- R6: 0x0D sets the column to 0. 0x0A moves the cursor down one row and keeps the column. 0x94 sets the cursor to column 0, row 0.
- R7: `cursor_pos` always equals row*56 + column.
- R8: ESC 'T' fills every cell from the cursor column through column 55 of the cursor row with {attribute, 0x20}. The cursor does not move.
- R9: 0x99, and ESC 'W', copy each cell right of the cursor one cell to the left within the row and write {attribute, 0x20} into column 55. The cursor does not move.
- R10: 0x08 at column 0 has no effect. At any other column it moves the cursor left one column and then performs the R9 shift from the new column.
- R11: ESC '`' '1' makes the cursor visible and ESC '`' '0' hides it. Any other third byte leaves visibility unchanged. None of these bytes is printed.
- R12: ESC '(' ESC 'G' '4' swaps the two nibbles of the attribute. The same prefix followed by any other final byte sets the attribute to 0xBF. Any byte that breaks the prefix returns the parser to idle without printing or changing the attribute.
- R13: While `busy` is high, input bytes are ignored. At most one of `buf_we`/`buf_re` is high in any cycle. A store issued during a sweep uses data read in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input byte |
| busy | output | 1 | Line-edit sweep in progress; input ignored |
| cursor_col | output | COL_W (6) | Cursor column |
| cursor_row | output | ROW_W (5) | Cursor row |
| cursor_pos | output | ADDR_W (11) | Linear cursor position row*COLS+column |
| attr | output | 8 | Current attribute |
| cursor_on | output | 1 | Cursor visible flag |
| scroll_up | output | 1 | One-cycle request to scroll the screen up |
| buf_we | output | 1 | Buffer write strobe |
| buf_re | output | 1 | Buffer read strobe |
| buf_addr | output | ADDR_W (11) | Buffer cell address |
| buf_wdata | output | 16 | Buffer write data {attribute, character} |
| buf_rdata | input | 16 | Buffer read data, valid the cycle after buf_re |

## Verification
A parser left in the wrong escape state is visible at the very next byte. That byte either fails to reach the buffer or the attribute and cursor flag change when they should not, so the bench checks buffer contents as well as the cursor after each escape sequence. A wrong sweep column or a lost fetch/store pairing shows up only when the sweep ends, as a misplaced or stale cell somewhere along the row. The bench therefore reads the cells on both sides of the edit point and the last column. A cursor register that goes past its limit shows up on `cursor_pos` in the same cycle, and again at the following write address.

// File: rtl/term_pkg.sv
package term_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ESC,
        ST_CURSW,
        ST_ATT_OPEN,
        ST_ATT_ESC,
        ST_ATT_SEL,
        ST_CLEAR,
        ST_FETCH,
        ST_STORE,
        ST_BLANK
    } state_t;

    typedef enum logic [3:0] {
        CMD_PRINT,
        CMD_RIGHT,
        CMD_LEFT,
        CMD_UP,
        CMD_DOWN,
        CMD_HOME,
        CMD_DEL,
        CMD_CR,
        CMD_LF,
        CMD_BS,
        CMD_ESC
    } cmd_t;

    localparam logic [7:0] CH_BS    = 8'h08;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_ESC   = 8'h1B;
    localparam logic [7:0] CH_UP    = 8'h90;
    localparam logic [7:0] CH_RIGHT = 8'h91;
    localparam logic [7:0] CH_DOWN  = 8'h92;
    localparam logic [7:0] CH_LEFT  = 8'h93;
    localparam logic [7:0] CH_HOME  = 8'h94;
    localparam logic [7:0] CH_DEL   = 8'h99;
    localparam logic [7:0] CH_SPACE = 8'h20;

endpackage

// File: rtl/term_code_decode.sv
module term_code_decode
    import term_pkg::*;
(
    input  logic [7:0] code,
    output cmd_t       cmd
);

    always_comb begin
        unique case (code)
            CH_BS:    cmd = CMD_BS;
            CH_LF:    cmd = CMD_LF;
            CH_CR:    cmd = CMD_CR;
            CH_ESC:   cmd = CMD_ESC;
            CH_UP:    cmd = CMD_UP;
            CH_RIGHT: cmd = CMD_RIGHT;
            CH_DOWN:  cmd = CMD_DOWN;
            CH_LEFT:  cmd = CMD_LEFT;
            CH_HOME:  cmd = CMD_HOME;
            CH_DEL:   cmd = CMD_DEL;
            default:  cmd = CMD_PRINT;
        endcase
    end

endmodule

// File: rtl/term_addr_map.sv
module term_addr_map #(
    parameter int COLS   = 56,
    parameter int ROW_W  = 5,
    parameter int COL_W  = 6,
    parameter int ADDR_W = 11
) (
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output logic [ADDR_W-1:0] addr
);

    assign addr = ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);

endmodule

// File: rtl/term_char_engine.sv
module term_char_engine
    import term_pkg::*;
#(
    parameter int          COLS       = 56,
    parameter int          ROWS       = 31,
    parameter logic [7:0]  ATTR_RESET = 8'hBF,
    localparam int         COL_W      = $clog2(COLS),
    localparam int         ROW_W      = $clog2(ROWS),
    localparam int         ADDR_W     = $clog2(COLS * ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              busy,
    output logic [COL_W-1:0]  cursor_col,
    output logic [ROW_W-1:0]  cursor_row,
    output logic [ADDR_W-1:0] cursor_pos,
    output logic [7:0]        attr,
    output logic              cursor_on,
    output logic              scroll_up,
    output logic              buf_we,
    output logic              buf_re,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [15:0]       buf_wdata,
    input  logic [15:0]       buf_rdata
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    state_t           state_q, state_d;
    logic [COL_W-1:0] col_q, col_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic [COL_W-1:0] wcol_q, wcol_d;
    logic [7:0]       attr_q, attr_d;
    logic             curs_q, curs_d;
    logic             scroll_q, scroll_d;
    logic             accept;
    logic [COL_W-1:0] acc_col;
    cmd_t             cmd;

    term_code_decode u_decode (
        .code (in_byte),
        .cmd  (cmd)
    );

    term_addr_map #(.COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_cur_map (
        .row  (row_q),
        .col  (col_q),
        .addr (cursor_pos)
    );

    term_addr_map #(.COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_buf_map (
        .row  (row_q),
        .col  (acc_col),
        .addr (buf_addr)
    );

    assign busy   = (state_q == ST_CLEAR) || (state_q == ST_FETCH) ||
                    (state_q == ST_STORE) || (state_q == ST_BLANK);
    assign accept = in_valid && !busy;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            col_q    <= '0;
            row_q    <= '0;
            wcol_q   <= '0;
            attr_q   <= ATTR_RESET;
            curs_q   <= 1'b1;
            scroll_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            col_q    <= col_d;
            row_q    <= row_d;
            wcol_q   <= wcol_d;
            attr_q   <= attr_d;
            curs_q   <= curs_d;
            scroll_q <= scroll_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        col_d    = col_q;
        row_d    = row_q;
        wcol_d   = wcol_q;
        attr_d   = attr_q;
        curs_d   = curs_q;
        scroll_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cmd)
                        CMD_PRINT: begin
                            if (col_q == LAST_COL) begin
                                col_d = '0;
                                if (row_q == LAST_ROW) scroll_d = 1'b1;
                                else                   row_d = row_q + 1'b1;
                            end else begin
                                col_d = col_q + 1'b1;
                            end
                        end
                        CMD_RIGHT: if (col_q != LAST_COL) col_d = col_q + 1'b1;
                        CMD_LEFT:  if (col_q != '0)       col_d = col_q - 1'b1;
                        CMD_DOWN:  if (row_q != LAST_ROW) row_d = row_q + 1'b1;
                        CMD_UP:    if (row_q != '0)       row_d = row_q - 1'b1;
                        CMD_HOME: begin
                            col_d = '0;
                            row_d = '0;
                        end
                        CMD_CR: col_d = '0;
                        CMD_LF: begin
                            if (row_q == LAST_ROW) scroll_d = 1'b1;
                            else                   row_d = row_q + 1'b1;
                        end
                        CMD_DEL: begin
                            wcol_d  = col_q;
                            state_d = (col_q == LAST_COL) ? ST_BLANK : ST_FETCH;
                        end
                        CMD_BS: begin
                            if (col_q != '0) begin
                                col_d   = col_q - 1'b1;
                                wcol_d  = col_q - 1'b1;
                                state_d = ST_FETCH;
                            end
                        end
                        CMD_ESC: state_d = ST_ESC;
                    endcase
                end
            end
            ST_ESC: begin
                if (accept) begin
                    case (in_byte)
                        8'h54: begin  // 'T'
                            wcol_d  = col_q;
                            state_d = ST_CLEAR;
                        end
                        8'h57: begin  // 'W'
                            wcol_d  = col_q;
                            state_d = (col_q == LAST_COL) ? ST_BLANK : ST_FETCH;
                        end
                        8'h60:   state_d = ST_CURSW;    // '`'
                        8'h28:   state_d = ST_ATT_OPEN; // '('
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_CURSW: begin
                if (accept) begin
                    if (in_byte == 8'h31)      curs_d = 1'b1;
                    else if (in_byte == 8'h30) curs_d = 1'b0;
                    state_d = ST_IDLE;
                end
            end
            ST_ATT_OPEN: begin
                if (accept) state_d = (in_byte == CH_ESC) ? ST_ATT_ESC : ST_IDLE;
            end
            ST_ATT_ESC: begin
                if (accept) state_d = (in_byte == 8'h47) ? ST_ATT_SEL : ST_IDLE;
            end
            ST_ATT_SEL: begin
                if (accept) begin
                    attr_d  = (in_byte == 8'h34) ? {attr_q[3:0], attr_q[7:4]} : ATTR_RESET;
                    state_d = ST_IDLE;
                end
            end
            ST_CLEAR: begin
                if (wcol_q == LAST_COL) state_d = ST_IDLE;
                else                    wcol_d  = wcol_q + 1'b1;
            end
            ST_FETCH: state_d = ST_STORE;
            ST_STORE: begin
                wcol_d  = wcol_q + 1'b1;
                state_d = (wcol_q + 1'b1 == LAST_COL) ? ST_BLANK : ST_FETCH;
            end
            ST_BLANK: state_d = ST_IDLE;
        endcase
    end

    // Buffer access outputs
    always_comb begin
        buf_we    = 1'b0;
        buf_re    = 1'b0;
        acc_col   = col_q;
        buf_wdata = {attr_q, in_byte};
        unique case (state_q)
            ST_IDLE:  buf_we = accept && (cmd == CMD_PRINT);
            ST_CLEAR: begin
                buf_we    = 1'b1;
                acc_col   = wcol_q;
                buf_wdata = {attr_q, CH_SPACE};
            end
            ST_FETCH: begin
                buf_re  = 1'b1;
                acc_col = wcol_q + 1'b1;
            end
            ST_STORE: begin
                buf_we    = 1'b1;
                acc_col   = wcol_q;
                buf_wdata = buf_rdata;
            end
            ST_BLANK: begin
                buf_we    = 1'b1;
                acc_col   = LAST_COL;
                buf_wdata = {attr_q, CH_SPACE};
            end
            default: ;
        endcase
    end

    assign cursor_col = col_q;
    assign cursor_row = row_q;
    assign attr       = attr_q;
    assign cursor_on  = curs_q;
    assign scroll_up  = scroll_q;

    // Assertions
    assert_cursor_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q <= LAST_COL) && (row_q <= LAST_ROW));

    assert_right_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q == ST_IDLE && cmd == CMD_RIGHT && col_q == LAST_COL)
        |=> (col_q == LAST_COL));

    assert_scroll_on_last_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        scroll_q |-> (row_q == LAST_ROW));

    assert_single_access_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we && buf_re));

    assert_cursor_frozen_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(row_q) && $stable(col_q)));

    assert_store_follows_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STORE) |-> $past(buf_re));

endmodule

// File: tb/test_term_char_engine.sv
module test_term_char_engine;

    localparam int COLS  = 56;
    localparam int CELLS = 56 * 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        busy;
    logic [5:0]  cursor_col;
    logic [4:0]  cursor_row;
    logic [10:0] cursor_pos;
    logic [7:0]  attr;
    logic        cursor_on;
    logic        scroll_up;
    logic        buf_we;
    logic        buf_re;
    logic [10:0] buf_addr;
    logic [15:0] buf_wdata;
    logic [15:0] buf_rdata;

    logic [15:0] mem [0:CELLS-1];
    int          n_checks = 0;
    int          n_fail = 0;
    logic        last_scroll = 1'b0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    term_char_engine i_term_char_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .busy       (busy),
        .cursor_col (cursor_col),
        .cursor_row (cursor_row),
        .cursor_pos (cursor_pos),
        .attr       (attr),
        .cursor_on  (cursor_on),
        .scroll_up  (scroll_up),
        .buf_we     (buf_we),
        .buf_re     (buf_re),
        .buf_addr   (buf_addr),
        .buf_wdata  (buf_wdata),
        .buf_rdata  (buf_rdata)
    );

    // Text buffer model: synchronous read, one cycle latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) mem[i] <= 16'h0000;
            buf_rdata <= 16'h0000;
        end else begin
            if (buf_we && buf_addr < 11'(CELLS)) mem[buf_addr] <= buf_wdata;
            if (buf_re && buf_addr < 11'(CELLS)) buf_rdata <= mem[buf_addr];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        last_scroll = scroll_up;
        while (busy) @(negedge clk);
    endtask

    task automatic send_n(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) send(b);
    endtask

    // {byte, expected column, expected row}
    localparam logic [18:0] VECS [11] = '{
        {8'h41, 6'd1, 5'd0},
        {8'h42, 6'd2, 5'd0},
        {8'h91, 6'd3, 5'd0},
        {8'h93, 6'd2, 5'd0},
        {8'h92, 6'd2, 5'd1},
        {8'h90, 6'd2, 5'd0},
        {8'h0D, 6'd0, 5'd0},
        {8'h0A, 6'd0, 5'd1},
        {8'h94, 6'd0, 5'd0},
        {8'h90, 6'd0, 5'd0},
        {8'h93, 6'd0, 5'd0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 col", 32'(cursor_col), 0);
        chk("R1 row", 32'(cursor_row), 0);
        chk("R1 pos", 32'(cursor_pos), 0);
        chk("R1 attr", 32'(attr), 32'hBF);
        chk("R1 cursor_on", 32'(cursor_on), 1);
        chk("R1 busy", 32'(busy), 0);

        // Vector walk: R2 print advance, R4 left/right, R5 up/down, R6 CR/LF/home
        for (int v = 0; v < 11; v++) begin
            send(VECS[v][18:11]);
            chk("R2,R4,R5,R6 vector col", 32'(cursor_col), 32'(VECS[v][10:5]));
            chk("R2,R4,R5,R6 vector row", 32'(cursor_row), 32'(VECS[v][4:0]));
        end
        chk("R2 cell A", 32'(mem[0]), 32'hBF41);
        chk("R2 cell B", 32'(mem[1]), 32'hBF42);

        // R7 linear position
        send_n(8'h92, 2);
        send_n(8'h91, 3);
        chk("R7 pos", 32'(cursor_pos), 2 * COLS + 3);
        send(8'h94);

        // R4 right edge
        send_n(8'h91, 60);
        chk("R4 right limit", 32'(cursor_col), 55);
        chk("R7 pos at edge", 32'(cursor_pos), 55);

        // R2 wrap
        send(8'h43);
        chk("R2 wrap cell", 32'(mem[55]), 32'hBF43);
        chk("R2 wrap col", 32'(cursor_col), 0);
        chk("R2 wrap row", 32'(cursor_row), 1);
        chk("R3 no scroll mid screen", 32'(last_scroll), 0);

        // R5 down limit, R3 scroll
        send_n(8'h92, 40);
        chk("R5 down limit", 32'(cursor_row), 30);
        send(8'h0A);
        chk("R3 LF scroll", 32'(last_scroll), 1);
        chk("R3 LF row", 32'(cursor_row), 30);
        send_n(8'h91, 60);
        send(8'h44);
        chk("R3 last cell", 32'(mem[30 * COLS + 55]), 32'hBF44);
        chk("R3 print scroll", 32'(last_scroll), 1);
        chk("R3 print col", 32'(cursor_col), 0);
        chk("R3 print row", 32'(cursor_row), 30);
        send(8'h94);

        // R11 cursor visibility
        send(8'h1B); send(8'h60); send(8'h30);
        chk("R11 cursor off", 32'(cursor_on), 0);
        send(8'h1B); send(8'h60); send(8'h31);
        chk("R11 cursor on", 32'(cursor_on), 1);
        send(8'h1B); send(8'h60); send(8'h78);
        chk("R11 other byte keeps", 32'(cursor_on), 1);
        chk("R11 nothing printed col", 32'(cursor_col), 0);
        chk("R11 nothing printed cell", 32'(mem[0]), 32'hBF41);

        // R12 attribute sequences
        send(8'h1B); send(8'h28); send(8'h1B); send(8'h47); send(8'h34);
        chk("R12 swap", 32'(attr), 32'hFB);
        send(8'h61);
        chk("R12 swapped attr written", 32'(mem[0]), 32'hFB61);
        send(8'h1B); send(8'h28); send(8'h1B); send(8'h47); send(8'h7A);
        chk("R12 default attr", 32'(attr), 32'hBF);
        send(8'h1B); send(8'h28); send(8'h71);
        chk("R12 abort attr", 32'(attr), 32'hBF);
        chk("R12 abort no print", 32'(cursor_col), 1);

        // R8 clear to end of line, row 2
        send(8'h94); send_n(8'h92, 2);
        send(8'h61); send(8'h62); send(8'h63); send(8'h64);
        send(8'h0D); send_n(8'h91, 2);
        send(8'h1B); send(8'h54);
        chk("R8 left cell kept", 32'(mem[2 * COLS + 1]), 32'hBF62);
        chk("R8 cursor cell cleared", 32'(mem[2 * COLS + 2]), 32'hBF20);
        chk("R8 last cell cleared", 32'(mem[2 * COLS + 55]), 32'hBF20);
        chk("R8 cursor held", 32'(cursor_col), 2);

        // R9 delete, row 3
        send(8'h0A); send(8'h0D);
        send(8'h61); send(8'h62); send(8'h63); send(8'h64);
        send(8'h0D); send(8'h91);
        send(8'h99);
        chk("R9 left kept", 32'(mem[3 * COLS + 0]), 32'hBF61);
        chk("R9 shifted c", 32'(mem[3 * COLS + 1]), 32'hBF63);
        chk("R9 shifted d", 32'(mem[3 * COLS + 2]), 32'hBF64);
        chk("R9 shifted empty", 32'(mem[3 * COLS + 3]), 0);
        chk("R9 last blank", 32'(mem[3 * COLS + 55]), 32'hBF20);
        chk("R9 cursor held", 32'(cursor_col), 1);
        send(8'h1B); send(8'h57);
        chk("R9 esc W shift", 32'(mem[3 * COLS + 1]), 32'hBF64);
        chk("R9 esc W cursor", 32'(cursor_col), 1);

        // R10 backspace, row 4
        send(8'h0A); send(8'h0D);
        send(8'h77); send(8'h78); send(8'h79); send(8'h7A);
        send(8'h08);
        chk("R10 col", 32'(cursor_col), 3);
        chk("R10 kept y", 32'(mem[4 * COLS + 2]), 32'hBF79);
        chk("R10 removed z", 32'(mem[4 * COLS + 3]), 0);
        chk("R10 last blank", 32'(mem[4 * COLS + 55]), 32'hBF20);
        send(8'h0D); send(8'h08);
        chk("R10 col0 no move", 32'(cursor_col), 0);
        chk("R10 col0 no shift", 32'(mem[4 * COLS + 0]), 32'hBF77);

        // R13 input ignored while busy
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = 8'h99;
        @(negedge clk);
        chk("R13 busy raised", 32'(busy), 1);
        in_byte = 8'h51;
        @(negedge clk);
        in_valid = 1'b0;
        while (busy) @(negedge clk);
        chk("R13 dropped byte cell", 32'(mem[4 * COLS + 0]), 32'hBF78);
        chk("R13 dropped byte col", 32'(cursor_col), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule